// File: doc/BRIEF.md
# Commit-Time Register Consolidation Writer

This block keeps a transfer file up to date. The transfer file holds one entry per logical register, and each entry holds the most recent committed value of that register in a multi-wide out-of-order core. Execution results arrive on writeback ports and are parked in a result buffer indexed by Active List slot. When an instruction commits, its commit lane names the slot and the destination logical register. The block then copies the buffered value into that register's transfer entry. Each lane has its own write path. When several lanes in one cycle commit the same register, only the youngest lane writes.

Next to the data, the block keeps one location bit per logical register, in two copies: a speculative copy used by rename, and a committed copy used for recovery. A value of 0 means the current value lives in the physical register file. A value of 1 means it lives in the transfer file. A migration sets every bit in both copies. Renaming a new producer clears the speculative bit, and committing a producer clears the committed bit. A pipeline recovery reloads the speculative copy from the committed one. The logic has no gating and runs every cycle, so the transfer file can be exchanged at any moment.

Top module: `xcons_writer`

## Requirements
- R1: A valid writeback port stores its data into the result buffer slot it names at the clock edge. Commits read that data from the following cycle on. When two writeback ports name the same slot in one cycle, the higher-numbered port wins.
- R2: A committing lane writes the buffer value of its slot into the transfer entry of its destination register at the clock edge. Transfer entries with no committing lane hold their value.
- R3: Commit lanes are ordered by age, with lane 0 the oldest. When valid lanes share a destination register, only the highest-numbered of them writes that entry.
- R4: A commit lane whose valid bit is low changes neither the transfer file nor the committed location bits, whatever its register and slot fields hold.
- R5: After reset, every transfer entry is zero, the result buffer reads as zero, and both location vectors are all zero.
- R6: A migration pulse sets all speculative and all committed location bits to 1 at the next edge.
- R7: A valid rename lane clears the speculative location bit of its logical register at the next edge.
- R8: A valid commit lane clears the committed location bit of its destination register at the next edge.
- R9: On a recovery pulse, the speculative location vector takes the committed vector as updated by that same cycle's commits, and rename clears in that cycle are discarded.
- R10: A migration pulse takes priority over rename clears, commit clears and recovery in the same cycle.
- R11: Transfer file writes from commits proceed unchanged in cycles with a migration or recovery pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbValid | input | WB_W | Writeback port valid bits |
| wbSlot | input | WB_W x SLOT_W | Active List slot per writeback port |
| wbData | input | WB_W x DATA_W | Result value per writeback port |
| cmtValid | input | COMMIT_W | Commit lane valid bits, lane 0 oldest |
| cmtLreg | input | COMMIT_W x LREG_W | Destination logical register per commit lane |
| cmtSlot | input | COMMIT_W x SLOT_W | Active List slot per commit lane |
| renValid | input | REN_W | Rename lane valid bits (new producer renamed) |
| renLreg | input | REN_W x LREG_W | Destination logical register per rename lane |
| migrate | input | 1 | Migration pulse: all values now in the transfer file |
| recover | input | 1 | Pipeline recovery pulse |
| xferFile | output | NUM_LREGS x DATA_W | Whole transfer file contents |
| locSpec | output | NUM_LREGS | Speculative location bits (1 = transfer file) |
| locArch | output | NUM_LREGS | Committed location bits (1 = transfer file) |

## Verification
The bench targets bursts in which several lanes commit the same register. A design that picked the oldest lane, or let lanes race, would leave a stale value in the transfer entry. Cycles where a writeback and a commit hit the same slot check that the commit reads the buffer value from before that edge. Collisions of migration with rename clears and with recovery expose a wrong priority: a design with the wrong order would leave some location bit at 0 after a migration. Recovery cycles that also carry commits catch a design that restores from the committed copy before that cycle's clears are applied. Cycles with invalid commit lanes that carry junk register fields catch a design that forgets to qualify the transfer write with the valid bit.

// File: rtl/xcons_pkg.sv
package xcons_pkg;

  // Location-bit control strobes passed from control to datapath.
  typedef struct packed {
    logic bulkSet;   // migration: every location bit goes to the transfer file
    logic restore;   // recovery: speculative copy reloads from committed copy
  } locStrobe_t;

endpackage

// File: rtl/xcons_ctrl.sv
module xcons_ctrl
  import xcons_pkg::*;
#(
  parameter int NUM_LREGS = 16,
  parameter int COMMIT_W  = 4,
  parameter int REN_W     = 2,
  localparam int LREG_W   = $clog2(NUM_LREGS)
) (
  input  logic [COMMIT_W-1:0]             cmtValid,
  input  logic [COMMIT_W-1:0][LREG_W-1:0] cmtLreg,
  input  logic [REN_W-1:0]                renValid,
  input  logic [REN_W-1:0][LREG_W-1:0]    renLreg,
  input  logic                            migrate,
  input  logic                            recover,
  output logic [COMMIT_W-1:0]             laneWr,
  output logic [NUM_LREGS-1:0]            cmtClr,
  output logic [NUM_LREGS-1:0]            renClr,
  output locStrobe_t                      strobe
);

  // Same-cycle write-after-write: a lane is dropped when any younger
  // valid lane names the same logical register.
  for (genvar l = 0; l < COMMIT_W; l++) begin : g_waw
    logic shadowed;
    always_comb begin
      shadowed = 1'b0;
      for (int y = l + 1; y < COMMIT_W; y++) begin
        if (cmtValid[y] && (cmtLreg[y] == cmtLreg[l])) shadowed = 1'b1;
      end
    end
    assign laneWr[l] = cmtValid[l] && !shadowed;
  end

  // Per-register decode of commit and rename clears.
  for (genvar r = 0; r < NUM_LREGS; r++) begin : g_dec
    logic cHit;
    logic rHit;
    always_comb begin
      cHit = 1'b0;
      for (int l = 0; l < COMMIT_W; l++) begin
        if (cmtValid[l] && (cmtLreg[l] == LREG_W'(r))) cHit = 1'b1;
      end
    end
    always_comb begin
      rHit = 1'b0;
      for (int l = 0; l < REN_W; l++) begin
        if (renValid[l] && (renLreg[l] == LREG_W'(r))) rHit = 1'b1;
      end
    end
    assign cmtClr[r] = cHit;
    assign renClr[r] = rHit;
  end

  // Migration outranks recovery; recovery outranks rename clears (datapath).
  always_comb begin
    strobe.bulkSet = migrate;
    strobe.restore = recover && !migrate;
  end

endmodule

// File: rtl/xcons_dpath.sv
module xcons_dpath
  import xcons_pkg::*;
#(
  parameter int NUM_LREGS = 16,
  parameter int DATA_W    = 32,
  parameter int AL_DEPTH  = 32,
  parameter int COMMIT_W  = 4,
  parameter int WB_W      = 2,
  localparam int LREG_W   = $clog2(NUM_LREGS),
  localparam int SLOT_W   = $clog2(AL_DEPTH)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [WB_W-1:0]                   wbValid,
  input  logic [WB_W-1:0][SLOT_W-1:0]       wbSlot,
  input  logic [WB_W-1:0][DATA_W-1:0]       wbData,
  input  logic [COMMIT_W-1:0][LREG_W-1:0]   cmtLreg,
  input  logic [COMMIT_W-1:0][SLOT_W-1:0]   cmtSlot,
  input  logic [COMMIT_W-1:0]               laneWr,
  input  logic [NUM_LREGS-1:0]              cmtClr,
  input  logic [NUM_LREGS-1:0]              renClr,
  input  locStrobe_t                        strobe,
  output logic [NUM_LREGS-1:0][DATA_W-1:0]  xferFile,
  output logic [NUM_LREGS-1:0]              locSpec,
  output logic [NUM_LREGS-1:0]              locArch
);

  // Result buffer: Active List side storage for values awaiting commit.
  logic [DATA_W-1:0] resBuf [AL_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < AL_DEPTH; i++) resBuf[i] <= '0;
    end else begin
      for (int p = 0; p < WB_W; p++) begin
        if (wbValid[p]) resBuf[wbSlot[p]] <= wbData[p];
      end
    end
  end

  // One read path per commit lane.
  logic [COMMIT_W-1:0][DATA_W-1:0] laneData;
  for (genvar l = 0; l < COMMIT_W; l++) begin : g_rd
    assign laneData[l] = resBuf[cmtSlot[l]];
  end

  // Transfer file entries and location bits, one slice per logical register.
  for (genvar r = 0; r < NUM_LREGS; r++) begin : g_reg
    logic [DATA_W-1:0] entryQ;
    logic [DATA_W-1:0] entryD;
    logic              specQ;
    logic              archQ;
    logic              archD;
    logic              specD;

    always_comb begin
      entryD = entryQ;
      for (int l = 0; l < COMMIT_W; l++) begin
        if (laneWr[l] && (cmtLreg[l] == LREG_W'(r))) entryD = laneData[l];
      end
    end

    always_comb begin
      if (strobe.bulkSet)  archD = 1'b1;
      else if (cmtClr[r])  archD = 1'b0;
      else                 archD = archQ;
    end

    always_comb begin
      if (strobe.bulkSet)       specD = 1'b1;
      else if (strobe.restore)  specD = archD;
      else if (renClr[r])       specD = 1'b0;
      else                      specD = specQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ <= '0;
        specQ  <= 1'b0;
        archQ  <= 1'b0;
      end else begin
        entryQ <= entryD;
        specQ  <= specD;
        archQ  <= archD;
      end
    end

    assign xferFile[r] = entryQ;
    assign locSpec[r]  = specQ;
    assign locArch[r]  = archQ;
  end

endmodule

// File: rtl/xcons_writer.sv
module xcons_writer
  import xcons_pkg::*;
#(
  parameter int NUM_LREGS = 16,
  parameter int DATA_W    = 32,
  parameter int AL_DEPTH  = 32,
  parameter int COMMIT_W  = 4,
  parameter int WB_W      = 2,
  parameter int REN_W     = 2,
  localparam int LREG_W   = $clog2(NUM_LREGS),
  localparam int SLOT_W   = $clog2(AL_DEPTH)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [WB_W-1:0]                   wbValid,
  input  logic [WB_W-1:0][SLOT_W-1:0]       wbSlot,
  input  logic [WB_W-1:0][DATA_W-1:0]       wbData,
  input  logic [COMMIT_W-1:0]               cmtValid,
  input  logic [COMMIT_W-1:0][LREG_W-1:0]   cmtLreg,
  input  logic [COMMIT_W-1:0][SLOT_W-1:0]   cmtSlot,
  input  logic [REN_W-1:0]                  renValid,
  input  logic [REN_W-1:0][LREG_W-1:0]      renLreg,
  input  logic                              migrate,
  input  logic                              recover,
  output logic [NUM_LREGS-1:0][DATA_W-1:0]  xferFile,
  output logic [NUM_LREGS-1:0]              locSpec,
  output logic [NUM_LREGS-1:0]              locArch
);

  logic [COMMIT_W-1:0]  laneWr;
  logic [NUM_LREGS-1:0] cmtClr;
  logic [NUM_LREGS-1:0] renClr;
  locStrobe_t           strobe;

  xcons_ctrl #(
    .NUM_LREGS(NUM_LREGS), .COMMIT_W(COMMIT_W), .REN_W(REN_W)
  ) u_ctrl (
    .cmtValid(cmtValid), .cmtLreg(cmtLreg),
    .renValid(renValid), .renLreg(renLreg),
    .migrate(migrate),   .recover(recover),
    .laneWr(laneWr),     .cmtClr(cmtClr), .renClr(renClr),
    .strobe(strobe)
  );

  xcons_dpath #(
    .NUM_LREGS(NUM_LREGS), .DATA_W(DATA_W), .AL_DEPTH(AL_DEPTH),
    .COMMIT_W(COMMIT_W),   .WB_W(WB_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .wbValid(wbValid), .wbSlot(wbSlot), .wbData(wbData),
    .cmtLreg(cmtLreg), .cmtSlot(cmtSlot), .laneWr(laneWr),
    .cmtClr(cmtClr),   .renClr(renClr),  .strobe(strobe),
    .xferFile(xferFile), .locSpec(locSpec), .locArch(locArch)
  );

endmodule

// File: rtl/xcons_checker.sv
module xcons_checker #(
  parameter int NUM_LREGS = 16,
  parameter int DATA_W    = 32,
  parameter int COMMIT_W  = 4,
  parameter int REN_W     = 2,
  localparam int LREG_W   = $clog2(NUM_LREGS)
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [COMMIT_W-1:0]               cmtValid,
  input logic [COMMIT_W-1:0][LREG_W-1:0]   cmtLreg,
  input logic [REN_W-1:0]                  renValid,
  input logic [REN_W-1:0][LREG_W-1:0]      renLreg,
  input logic                              migrate,
  input logic                              recover,
  input logic [NUM_LREGS-1:0][DATA_W-1:0]  xferFile,
  input logic [NUM_LREGS-1:0]              locSpec,
  input logic [NUM_LREGS-1:0]              locArch
);

  // R6 and R10: migration fills both location copies regardless of other inputs.
  p_migrate_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    migrate |=> ((&locSpec) && (&locArch)));

  // R7: a renamed producer moves its register back to the physical file.
  p_rename_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (renValid[0] && !migrate && !recover) |=> !locSpec[$past(renLreg[0])]);

  // R8: a commit clears the committed location bit.
  p_commit_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid[0] && !migrate) |=> !locArch[$past(cmtLreg[0])]);

  // R9: after recovery both location copies agree.
  p_recover_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (recover && !migrate) |=> (locSpec == locArch));

  // R4: no valid commit lane means the transfer file holds.
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(|cmtValid) |=> $stable(xferFile));

endmodule

bind xcons_writer xcons_checker #(
  .NUM_LREGS(NUM_LREGS), .DATA_W(DATA_W), .COMMIT_W(COMMIT_W), .REN_W(REN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmtValid(cmtValid), .cmtLreg(cmtLreg),
  .renValid(renValid), .renLreg(renLreg), .migrate(migrate), .recover(recover),
  .xferFile(xferFile), .locSpec(locSpec), .locArch(locArch)
);

// File: tb/xcons_writer_bench.sv
`timescale 1ns/1ps
module xcons_writer_bench;

  localparam int NL = 16;
  localparam int DW = 32;
  localparam int AD = 32;
  localparam int CW = 4;
  localparam int WW = 2;
  localparam int RW = 2;
  localparam int LW = $clog2(NL);
  localparam int SW = $clog2(AD);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WW-1:0]          wbValid = '0;
  logic [WW-1:0][SW-1:0]  wbSlot  = '0;
  logic [WW-1:0][DW-1:0]  wbData  = '0;
  logic [CW-1:0]          cmtValid = '0;
  logic [CW-1:0][LW-1:0]  cmtLreg  = '0;
  logic [CW-1:0][SW-1:0]  cmtSlot  = '0;
  logic [RW-1:0]          renValid = '0;
  logic [RW-1:0][LW-1:0]  renLreg  = '0;
  logic migrate = 1'b0;
  logic recover = 1'b0;
  logic [NL-1:0][DW-1:0]  xferFile;
  logic [NL-1:0]          locSpec;
  logic [NL-1:0]          locArch;

  always #2 clk = ~clk;  // 250 MHz

  xcons_writer #(
    .NUM_LREGS(NL), .DATA_W(DW), .AL_DEPTH(AD),
    .COMMIT_W(CW), .WB_W(WW), .REN_W(RW)
  ) u_xcons_writer (.*);

  // Behavioural reference state.
  logic [DW-1:0] mBuf  [AD];
  logic [DW-1:0] mXfer [NL];
  logic [NL-1:0] mSpec;
  logic [NL-1:0] mArch;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string tagX, tagS, tagA;

  task automatic modelReset();
    for (int i = 0; i < AD; i++) mBuf[i] = '0;
    for (int i = 0; i < NL; i++) mXfer[i] = '0;
    mSpec = '0;
    mArch = '0;
  endtask

  // Sequential, program-order view of one cycle.
  task automatic modelStep();
    for (int l = 0; l < CW; l++) begin
      if (cmtValid[l]) begin
        mXfer[cmtLreg[l]] = mBuf[cmtSlot[l]];
        mArch[cmtLreg[l]] = 1'b0;
      end
    end
    for (int l = 0; l < RW; l++) if (renValid[l]) mSpec[renLreg[l]] = 1'b0;
    if (recover) mSpec = mArch;
    if (migrate) begin
      mSpec = '1;
      mArch = '1;
    end
    for (int p = 0; p < WW; p++) if (wbValid[p]) mBuf[wbSlot[p]] = wbData[p];
  endtask

  task automatic compareAll();
    int bad;
    bad = -1;
    for (int r = 0; r < NL; r++) if (xferFile[r] !== mXfer[r] && bad < 0) bad = r;
    compared++;
    if (bad >= 0) begin
      mismatched++;
      $display("FAIL %s transfer entry %0d: actual %h expected %h",
               tagX, bad, xferFile[bad], mXfer[bad]);
    end
    compared++;
    if (locSpec !== mSpec) begin
      mismatched++;
      $display("FAIL %s speculative location: actual %h expected %h", tagS, locSpec, mSpec);
    end
    compared++;
    if (locArch !== mArch) begin
      mismatched++;
      $display("FAIL %s committed location: actual %h expected %h", tagA, locArch, mArch);
    end
  endtask

  // kind: 0 random, 1 conflict-heavy, 2 migrate, 3 recover, 4 migrate+recover,
  //       5 invalid lanes with junk fields, 6 all lanes same register
  task automatic drive(int kind);
    for (int p = 0; p < WW; p++) begin
      wbValid[p] = ($urandom_range(0, 3) != 0);
      wbSlot[p]  = SW'($urandom_range(0, AD - 1));
      wbData[p]  = DW'($urandom);
    end
    for (int l = 0; l < CW; l++) begin
      cmtValid[l] = ($urandom_range(0, 2) != 0);
      cmtLreg[l]  = (kind == 1) ? LW'($urandom_range(0, 1)) : LW'($urandom_range(0, NL - 1));
      cmtSlot[l]  = SW'($urandom_range(0, AD - 1));
    end
    if (kind == 6) begin
      cmtValid = '1;
      for (int l = 0; l < CW; l++) cmtLreg[l] = cmtLreg[0];
    end
    if (kind == 5) cmtValid = '0;
    for (int l = 0; l < RW; l++) begin
      renValid[l] = ($urandom_range(0, 1) != 0);
      renLreg[l]  = LW'($urandom_range(0, NL - 1));
    end
    migrate = (kind == 2 || kind == 4) ? ($urandom_range(0, 2) == 0) : 1'b0;
    recover = (kind == 3 || kind == 4) ? ($urandom_range(0, 2) == 0) : 1'b0;
    if (kind == 0 || kind == 1 || kind == 6) migrate = ($urandom_range(0, 15) == 0);
  endtask

  task automatic setTags(int kind);
    case (kind)
      0: begin tagX = "R1"; tagS = "R7";  tagA = "R8";  end
      1: begin tagX = "R3"; tagS = "R7";  tagA = "R8";  end
      2: begin tagX = "R11"; tagS = "R10"; tagA = "R6"; end
      3: begin tagX = "R2"; tagS = "R9";  tagA = "R8";  end
      4: begin tagX = "R11"; tagS = "R10"; tagA = "R10"; end
      5: begin tagX = "R4"; tagS = "R7";  tagA = "R4";  end
      default: begin tagX = "R3"; tagS = "R7"; tagA = "R8"; end
    endcase
  endtask

  initial begin
    modelReset();
    tagX = "R5"; tagS = "R5"; tagA = "R5";
    repeat (3) @(negedge clk);
    compareAll();            // R5 reset state
    rstN = 1'b1;
    for (int phase = 0; phase < 14; phase++) begin
      int kind;
      kind = phase % 7;
      for (int c = 0; c < 250; c++) begin
        @(negedge clk);
        compareAll();
        setTags(kind);
        drive(kind);
        modelStep();
      end
    end
    @(negedge clk);
    compareAll();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule